// File: doc/BRIEF.md
# Registered ALU Datapath with Accumulator Feedback

This block puts a combinational ALU between two operand registers on the input side and one result register on the output side. All three registers share one rising clock edge. Each input register loads while its active-low load strobe is low. One bypass control routes the raw operand ports around both input registers. The registers keep loading under their strobes while they are bypassed, so releasing the bypass exposes whatever they captured in the meantime. The result register behaves the same way: it has an active-low load strobe and its own bypass. The result reaches a shared bus through tri-state drivers that an active-high output enable controls.

A pair of operand-select lines sits in front of the ALU. It can force either operand to zero, or replace the B operand with the contents of the result register. The second option turns the datapath into an accumulator. A select value that zeroes B preloads the accumulator from A. Repeated additions in chain mode then accumulate a stream of A values. Function code zero clears the accumulator. The feedback always comes from the result register, never from the bypass path, so output bypass does not disturb chaining.

Top module: `regalu_top`

## Requirements
- R1: A synchronous reset (active-low `rst_n` sampled on the rising edge) clears both operand registers and the result register, so after reset, with output bypass off and the output enabled, the bus reads zero.
- R2: The A register captures `a_in` on a rising edge when `a_load_n` is 0 and keeps its value when `a_load_n` is 1. The B register does the same with `b_in` and `b_load_n`.
- R3: While `in_bypass` is 1, the ALU takes its operands from `a_in` and `b_in` directly, and the operand registers keep loading under their strobes. Once `in_bypass` returns to 0, the ALU again uses the register contents.
- R4: The result register captures the ALU output on a rising edge when `f_load_n` is 0 and holds its value when `f_load_n` is 1. With `out_bypass` at 0, the bus shows the result register.
- R5: While `out_bypass` is 1, the bus shows the combinational ALU output, and the result register keeps loading or holding under `f_load_n`.
- R6: `op_sel[1:0]` chooses the ALU operands (A side, B side) as follows: 00 = (A operand, result register), 01 = (A operand, 0), 10 = (0, B operand), 11 = (A operand, B operand). The A and B operands are register contents or raw ports, depending on `in_bypass`.
- R7: In chain mode (00), the B side always takes the result register contents, even while `out_bypass` is 1.
- R8: `fn[2:0]` chooses the ALU function: 000 = all zeros, 001 = B minus A, 010 = A minus B, 011 = A plus B, 100 = A xor B, 101 = A or B, 110 = A and B, 111 = all ones. Arithmetic is modulo 2^W.
- R9: When `out_en` is 0, the block does not drive `f_bus`, and a value placed on the bus by another driver reads back unchanged. When `out_en` is 1, the block drives the bus.
- R10: Preloading with select 01 and then adding a series of A values in chain mode leaves the running sum modulo 2^W in the result register. Function 000 then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | A operand port |
| b_in | input | W | B operand port |
| a_load_n | input | 1 | Active-low load strobe of the A register |
| b_load_n | input | 1 | Active-low load strobe of the B register |
| in_bypass | input | 1 | Route the operand ports around the input registers |
| op_sel | input | 2 | Operand select (A side, B side) per R6 |
| fn | input | 3 | ALU function code per R8 |
| f_load_n | input | 1 | Active-low load strobe of the result register |
| out_bypass | input | 1 | Show the ALU output instead of the result register |
| out_en | input | 1 | Drive the result bus when 1 |
| f_bus | inout | W | Tri-state result bus |

## Verification
The bench builds the block with W = 16, which is also the default. At this width, accumulating values near 0xFFFF wraps the running sum past 2^16 within a few additions. Subtraction underflow also shows up with small operands. Both effects make the modulo behaviour of R8 and R10 visible after a short sequence. Every bit of the result path, including the all-ones code, is checked against a behavioural model in the bench.

// File: rtl/regalu_pkg.sv
// Shared encodings for the registered ALU datapath.
// Assumes: function and select codes are fixed by the block's requirements.
package regalu_pkg;

    // ALU function codes (R8)
    typedef enum logic [2:0] {
        FN_ZERO  = 3'b000,
        FN_BSUBA = 3'b001,
        FN_ASUBB = 3'b010,
        FN_ADD   = 3'b011,
        FN_XOR   = 3'b100,
        FN_OR    = 3'b101,
        FN_AND   = 3'b110,
        FN_ONES  = 3'b111
    } alu_fn_e;

    // Operand select codes, bit 1 = B side, bit 0 = A side (R6)
    typedef enum logic [1:0] {
        SEL_CHAIN  = 2'b00,
        SEL_LOADA  = 2'b01,
        SEL_ZEROA  = 2'b10,
        SEL_PASS   = 2'b11
    } opnd_sel_e;

endpackage

// File: rtl/opnd_stage.sv
// One operand input register with a bypass path.
// The register loads on the rising edge while load_n is low and holds otherwise.
// The bypass only steers the output; the register keeps operating.
// Assumes: synchronous active-low reset.
module opnd_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         load_n,
    input  logic         bypass,
    output logic [W-1:0] q,
    output logic [W-1:0] o
);

    logic [W-1:0] q_r;

    // Capture the operand under the active-low strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= '0;
        else if (!load_n) q_r <= d;
    end

    // Present either the raw port or the stored value to the ALU.
    always_comb begin
        o = bypass ? d : q_r;
    end

    assign q = q_r;

endmodule

// File: rtl/opnd_select.sv
// Operand-select multiplexers ahead of the ALU.
// They force either side to zero, or feed the result register back into the B side.
// Assumes: fb is the result register itself, never the bypassed ALU output.
module opnd_select
    import regalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    input  logic [W-1:0] fb,
    output logic [W-1:0] alu_a,
    output logic [W-1:0] alu_b
);

    opnd_sel_e sel_e;
    assign sel_e = opnd_sel_e'(sel);

    // Choose the operand pair according to the select code.
    always_comb begin
        unique case (sel_e)
            SEL_CHAIN: begin alu_a = a_op; alu_b = fb;   end
            SEL_LOADA: begin alu_a = a_op; alu_b = '0;   end
            SEL_ZEROA: begin alu_a = '0;   alu_b = b_op; end
            default:   begin alu_a = a_op; alu_b = b_op; end
        endcase
    end

endmodule

// File: rtl/alu_core.sv
// Combinational eight-function ALU, modulo 2^W arithmetic.
// Assumes: no carry in or carry out; the cascade logic lies outside this block.
module alu_core
    import regalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] f
);

    alu_fn_e fn_e;
    assign fn_e = alu_fn_e'(fn);

    // Evaluate the selected function.
    always_comb begin
        unique case (fn_e)
            FN_ZERO:  f = '0;
            FN_BSUBA: f = b - a;
            FN_ASUBB: f = a - b;
            FN_ADD:   f = a + b;
            FN_XOR:   f = a ^ b;
            FN_OR:    f = a | b;
            FN_AND:   f = a & b;
            default:  f = '1;
        endcase
    end

endmodule

// File: rtl/result_stage.sv
// Result register with a bypass path to the output.
// The register loads the ALU output while load_n is low. With bypass high,
// the output shows the ALU result directly and the register keeps operating.
// Assumes: synchronous active-low reset.
module result_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] f,
    input  logic         load_n,
    input  logic         bypass,
    output logic [W-1:0] q,
    output logic [W-1:0] o
);

    logic [W-1:0] q_r;

    // Capture the ALU result under the active-low strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= '0;
        else if (!load_n) q_r <= f;
    end

    // Pick the value presented to the bus drivers.
    always_comb begin
        o = bypass ? f : q_r;
    end

    assign q = q_r;

endmodule

// File: rtl/regalu_top.sv
// Registered ALU datapath: operand registers, operand select, ALU,
// result register, and a tri-state result bus.
// Assumes: a single clock; the feedback for chaining always takes the result register.
module regalu_top #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_load_n,
    input  logic         b_load_n,
    input  logic         in_bypass,
    input  logic [1:0]   op_sel,
    input  logic [2:0]   fn,
    input  logic         f_load_n,
    input  logic         out_bypass,
    input  logic         out_en,
    inout  wire  [W-1:0] f_bus
);

    logic [W-1:0] a_q, b_q, a_op, b_op;
    logic [W-1:0] alu_a, alu_b, alu_f;
    logic [W-1:0] f_q, f_drv;

    opnd_stage #(.W(W)) u_a (
        .clk(clk), .rst_n(rst_n), .d(a_in), .load_n(a_load_n),
        .bypass(in_bypass), .q(a_q), .o(a_op)
    );

    opnd_stage #(.W(W)) u_b (
        .clk(clk), .rst_n(rst_n), .d(b_in), .load_n(b_load_n),
        .bypass(in_bypass), .q(b_q), .o(b_op)
    );

    opnd_select #(.W(W)) u_sel (
        .sel(op_sel), .a_op(a_op), .b_op(b_op), .fb(f_q),
        .alu_a(alu_a), .alu_b(alu_b)
    );

    alu_core #(.W(W)) u_alu (
        .fn(fn), .a(alu_a), .b(alu_b), .f(alu_f)
    );

    result_stage #(.W(W)) u_res (
        .clk(clk), .rst_n(rst_n), .f(alu_f), .load_n(f_load_n),
        .bypass(out_bypass), .q(f_q), .o(f_drv)
    );

    // Tri-state drivers onto the shared result bus.
    assign f_bus = out_en ? f_drv : {W{1'bz}};

endmodule

// File: rtl/regalu_chk.sv
// Assertion checker for regalu_top, attached through bind.
// Assumes: the signals bound below are the register and ALU nets of the top module.
module regalu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         a_load_n,
    input logic         b_load_n,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic         f_load_n,
    input logic [W-1:0] f_q,
    input logic [W-1:0] alu_f,
    input logic [2:0]   fn,
    input logic         out_bypass,
    input logic [W-1:0] f_drv
);

    // R2
    a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_load_n |=> a_q == $past(a_in));
    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_load_n |=> a_q == $past(a_q));
    // R2
    b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_load_n |=> b_q == $past(b_in));
    // R2
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_load_n |=> b_q == $past(b_q));
    // R4
    f_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_load_n |=> f_q == $past(alu_f));
    // R4
    f_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_load_n |=> f_q == $past(f_q));
    // R8
    zero_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fn == 3'b000 |-> alu_f == '0);
    // R5
    byp_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bypass |-> f_drv == alu_f);
    // R4
    reg_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_bypass |-> f_drv == f_q);

endmodule

bind regalu_top regalu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_load_n(a_load_n), .b_load_n(b_load_n), .a_q(a_q), .b_q(b_q),
    .f_load_n(f_load_n), .f_q(f_q), .alu_f(alu_f), .fn(fn),
    .out_bypass(out_bypass), .f_drv(f_drv)
);

// File: tb/tb_regalu_top.sv
`timescale 1ns/1ps
module tb_regalu_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic a_load_n = 1'b1, b_load_n = 1'b1, in_bypass = 1'b0;
    logic [1:0] op_sel = 2'b11;
    logic [2:0] fn = 3'b011;
    logic f_load_n = 1'b1, out_bypass = 1'b0, out_en = 1'b1;
    logic tb_drv = 1'b0;
    logic [W-1:0] tb_pat = 16'hC3A5;
    wire  [W-1:0] f_bus;

    assign f_bus = tb_drv ? tb_pat : {W{1'bz}};

    always #10 clk = ~clk;

    regalu_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .in_bypass(in_bypass),
        .op_sel(op_sel), .fn(fn), .f_load_n(f_load_n),
        .out_bypass(out_bypass), .out_en(out_en), .f_bus(f_bus)
    );

    // Behavioural reference state
    logic [W-1:0] ma = '0, mb = '0, mf = '0;
    int n_chk = 0, n_bad = 0;
    string tag = "R1";
    logic [W-1:0] run_sum;

    function automatic logic [W-1:0] ref_alu(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        case (c)
            3'd0: return '0;
            3'd1: return y - x;
            3'd2: return x - y;
            3'd3: return x + y;
            3'd4: return x ^ y;
            3'd5: return x | y;
            3'd6: return x & y;
            default: return '1;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_result();
        logic [W-1:0] xa, xb, sa, sb;
        xa = in_bypass ? a_in : ma;
        xb = in_bypass ? b_in : mb;
        case (op_sel)
            2'b00: begin sa = xa; sb = mf; end
            2'b01: begin sa = xa; sb = '0; end
            2'b10: begin sa = '0; sb = xb; end
            default: begin sa = xa; sb = xb; end
        endcase
        return ref_alu(fn, sa, sb);
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare the bus at the falling edge, then advance the model at the rising edge.
    task automatic cyc();
        logic [W-1:0] r;
        @(negedge clk);
        r = ref_result();
        if (out_en) check(tag, f_bus, out_bypass ? r : mf);
        else        check(tag, f_bus, tb_pat);
        @(posedge clk);
        if (!rst_n) begin ma = '0; mb = '0; mf = '0; end
        else begin
            if (!f_load_n) mf = r;
            if (!a_load_n) ma = a_in;
            if (!b_load_n) mb = b_in;
        end
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: preload junk, then reset
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        cyc(); cyc();
        rst_n = 1'b1;
        tag = "R1"; cyc();

        // R2: load A and B, then hold with changed ports
        tag = "R2";
        a_in = 16'h1234; b_in = 16'h0F0F; a_load_n = 0; b_load_n = 0; cyc();
        a_load_n = 1; b_load_n = 1; a_in = 16'hAAAA; b_in = 16'h5555;
        f_load_n = 0; cyc();
        f_load_n = 1; cyc();
        a_load_n = 0; cyc();            // A only
        a_load_n = 1; f_load_n = 0; cyc(); cyc();

        // R8: every function with register operands
        tag = "R8";
        a_in = 16'h0003; b_in = 16'h0010; a_load_n = 0; b_load_n = 0; cyc();
        a_load_n = 1; b_load_n = 1; out_bypass = 1;
        for (int k = 0; k < 8; k++) begin fn = 3'(k); cyc(); end
        a_in = 16'hF0F0; b_in = 16'h0001; a_load_n = 0; b_load_n = 0; cyc();
        a_load_n = 1; b_load_n = 1;
        for (int k = 0; k < 8; k++) begin fn = 3'(k); cyc(); end
        out_bypass = 0; fn = 3'b011; cyc();

        // R4: result hold while ALU output changes
        tag = "R4";
        f_load_n = 1; a_in = 16'h7777; a_load_n = 0; cyc(); cyc();
        a_load_n = 1; f_load_n = 0; cyc(); cyc();

        // R3: bypass uses raw ports while registers keep loading
        tag = "R3";
        in_bypass = 1; out_bypass = 1; a_in = 16'h0100; b_in = 16'h0020;
        a_load_n = 0; b_load_n = 0; cyc();
        a_in = 16'h0001; b_in = 16'h0002; a_load_n = 1; b_load_n = 1; cyc();
        in_bypass = 0; cyc(); cyc();

        // R6: all operand select codes
        tag = "R6";
        a_in = 16'h4000; b_in = 16'h0321; a_load_n = 0; b_load_n = 0; cyc();
        a_load_n = 1; b_load_n = 1;
        for (int k = 0; k < 4; k++) begin op_sel = 2'(k); cyc(); end
        fn = 3'b100;
        for (int k = 0; k < 4; k++) begin op_sel = 2'(k); cyc(); end
        fn = 3'b011; op_sel = 2'b11;

        // R5: output bypass while the register holds and then loads
        tag = "R5";
        out_bypass = 1; f_load_n = 1; a_in = 16'h0009; a_load_n = 0; cyc(); cyc();
        a_load_n = 1; out_bypass = 0; cyc();
        out_bypass = 1; f_load_n = 0; cyc(); out_bypass = 0; cyc();

        // R9: released bus reads back another driver
        tag = "R9";
        out_en = 0; tb_drv = 1; cyc(); tb_pat = 16'h0FF0; cyc();
        tb_drv = 0; out_en = 1; cyc();

        // R10 / R7: preload then accumulate, output bypass toggling
        tag = "R10";
        in_bypass = 1; op_sel = 2'b01; fn = 3'b011; f_load_n = 0;
        a_in = 16'hFFF0; run_sum = 16'hFFF0; cyc();
        op_sel = 2'b00;
        for (int k = 0; k < 12; k++) begin
            tag = (k % 2) ? "R7" : "R10";
            out_bypass = k[0];
            a_in = (k % 3 == 0) ? 16'hFFFF : 16'(k * 16'h1357);
            run_sum = run_sum + a_in;
            cyc();
        end
        out_bypass = 0; f_load_n = 1; tag = "R10";
        @(negedge clk); check("R10", f_bus, run_sum); @(posedge clk); #1;
        fn = 3'b000; f_load_n = 0; cyc(); cyc();
        @(negedge clk); check("R10", f_bus, 16'h0000); @(posedge clk); #1;

        // R1: reset from a loaded state
        tag = "R1";
        fn = 3'b011; op_sel = 2'b11; in_bypass = 0; a_in = 16'h00FF; a_load_n = 0; cyc();
        a_load_n = 1; rst_n = 0; cyc(); rst_n = 1; f_load_n = 1; cyc();
        @(negedge clk); check("R1", f_bus, 16'h0000); @(posedge clk); #1;

        finish_run();
    end
endmodule